// File: doc/BRIEF.md
# Nine-Bit Multiprocessor UART

An asynchronous serial transmitter and receiver sharing one set of frame settings. In the normal format a frame carries eight data bits, least significant first, followed by an optional even or odd parity bit. In the multiprocessor format the slot after the last data bit holds a control bit instead. Several processors sharing one line can use that bit, for example to mark address frames. Parity is not available in that format. Either format ends with one or two stop bits. A free-running divide-by-`CLK_DIV` counter produces a 16x oversampling tick for both directions.

The transmitter is a state machine with the states TX_IDLE, TX_START, TX_DATA, TX_XBIT, TX_STOP1 and TX_STOP2:

- TX_IDLE moves to TX_START when `tx_start` is seen.
- TX_START moves to TX_DATA after one bit time.
- TX_DATA moves after its eighth bit, to TX_XBIT when a ninth bit is configured and to TX_STOP1 otherwise.
- TX_XBIT moves to TX_STOP1.
- TX_STOP1 moves to TX_STOP2 when two stop bits are set, and back to TX_IDLE otherwise.
- TX_STOP2 moves to TX_IDLE.

The receiver uses the states RX_IDLE, RX_START, RX_DATA, RX_XBIT, RX_STOP1, RX_STOP2 and RX_REARM:

- RX_IDLE moves to RX_START on a low line.
- RX_START checks the line at half a bit. It moves to RX_DATA if the line is still low and back to RX_IDLE if it is high.
- RX_DATA moves to RX_XBIT or RX_STOP1 in the same way as the transmitter.
- RX_XBIT moves to RX_STOP1.
- RX_STOP1 moves to RX_REARM when the stop bit is low. Otherwise it moves to RX_STOP2 when two stop bits are set, or to RX_IDLE.
- RX_STOP2 moves to RX_REARM on a low stop bit and to RX_IDLE on a high one.
- RX_REARM waits for a high line and then moves to RX_IDLE.
- Whenever receive enable is low, the receiver is forced to RX_IDLE.

Top module: `ninebit_uart`

## Requirements
- R1: The transmit line is high after reset and while idle. A frame starts with one low bit. `tx_busy` is high from the accepted `tx_start` until the last stop bit has been sent.
- R2: The data bits follow the start bit, bit 0 first and bit 7 last. Each bit lasts 16 ticks of `CLK_DIV` clocks each. A `tx_start` seen while `tx_busy` is high is ignored.
- R3: With `cfg_mp_mode`=0 and `cfg_par_en`=1, a parity bit follows bit 7. It is the XOR of the eight data bits when `cfg_par_odd`=0 (even) and its inverse when `cfg_par_odd`=1 (odd). With `cfg_par_en`=0 no bit follows bit 7.
- R4: With `cfg_mp_mode`=1, the transmitter places `tx_mp_bit` right after bit 7 and `cfg_par_en` has no effect. The receiver returns that bit on `rx_mp_bit` and never flags a parity error. Outside this mode `rx_mp_bit` reads 0.
- R5: The frame ends with one high stop bit, or with two when `cfg_two_stop`=1. The receiver expects the same count.
- R6: While `cfg_rx_en`=0 the receiver accepts no frame, and `rx_valid` does not rise.
- R7: A low pulse on `rxd` that is high again at half a bit time after its falling edge is not taken as a start bit.
- R8: With parity enabled and `cfg_mp_mode`=0, a received ninth bit that differs from the computed parity sets `rx_par_err`.
- R9: A stop bit sampled low sets `rx_frm_err`. The receiver then waits for a high line before it looks for a new start bit, and a following good frame is received correctly.
- R10: A frame whose data bits and ninth bit are all 0 and whose first stop bit is low sets `rx_brk` together with `rx_frm_err`.
- R11: When a frame completes, `rx_data` and the flags are loaded and `rx_valid` is set. A one-cycle `rx_read` pulse clears `rx_valid` and all error flags.
- R12: A frame that completes while `rx_valid` is still set sets `rx_ovr`, and the new frame's data replaces the old data.
- R13: `rx_err` is high exactly when any of `rx_par_err`, `rx_frm_err`, `rx_brk` or `rx_ovr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_par_en | input | 1 | Parity enable (normal format only) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_mp_mode | input | 1 | Multiprocessor nine-bit format |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| tx_data | input | DATA_W | Byte to send |
| tx_mp_bit | input | 1 | Control bit to send in multiprocessor format |
| tx_start | input | 1 | Start a frame (taken only when idle) |
| tx_busy | output | 1 | Transmitter busy |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_read | input | 1 | Data read strobe; clears valid and flags |
| rx_data | output | DATA_W | Received byte |
| rx_mp_bit | output | 1 | Received control bit |
| rx_valid | output | 1 | Received data available |
| rx_par_err | output | 1 | Parity error |
| rx_frm_err | output | 1 | Framing error |
| rx_brk | output | 1 | Break detected |
| rx_ovr | output | 1 | Overrun |
| rx_err | output | 1 | Any receive error |

## Verification
The bench builds the block with `CLK_DIV`=2 and the default 16x oversampling and eight data bits, so a bit lasts 32 clocks. About twenty frames in both directions therefore fit comfortably in a short run. Because the tick counter runs freely, a divider above 1 lets the start bit vary in length by up to one tick. That brings the tick phase into play, and the bench still samples each bit within its middle. The same setting leaves a start-bit glitch of a quarter bit long enough to reach the receiver and short enough to be rejected at the half-bit check.

// File: rtl/nbu_pkg.sv
package nbu_pkg;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_XBIT, TX_STOP1, TX_STOP2
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_XBIT, RX_STOP1, RX_STOP2, RX_REARM
    } rx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic mp_mode;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/nbu_tick.sv
module nbu_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV - 1));

    generate
        if (DIV > 1) begin : g_gap_chk
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/nbu_tx.sv
module nbu_tx
    import nbu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] data,
    input  logic              mp_bit,
    input  logic              start,
    output logic              busy,
    output logic              txd
);
    localparam int OVS_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         st, nx;
    logic [OVS_W-1:0]  ocnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              xb;
    frame_cfg_t        cl;
    logic              bit_end, has_x, line_nx;

    assign bit_end = tick && (ocnt == OVS_W'(OVS - 1));
    assign has_x   = cl.mp_mode || cl.par_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            TX_IDLE:  if (start) nx = TX_START;
            TX_START: if (bit_end) nx = TX_DATA;
            TX_DATA:  if (bit_end && idx == IDX_W'(DATA_W - 1))
                          nx = has_x ? TX_XBIT : TX_STOP1;
            TX_XBIT:  if (bit_end) nx = TX_STOP1;
            TX_STOP1: if (bit_end) nx = cl.two_stop ? TX_STOP2 : TX_IDLE;
            TX_STOP2: if (bit_end) nx = TX_IDLE;
            default:  nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt <= '0;
            idx  <= '0;
            sh   <= '0;
            xb   <= 1'b0;
            cl   <= '0;
        end else if (st == TX_IDLE) begin
            ocnt <= '0;
            idx  <= '0;
            if (start) begin
                sh <= data;
                cl <= cfg;
                xb <= cfg.mp_mode ? mp_bit : ((^data) ^ cfg.par_odd);
            end
        end else if (tick) begin
            ocnt <= bit_end ? '0 : ocnt + 1'b1;
            if (bit_end && st == TX_DATA) begin
                sh  <= sh >> 1;
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        busy = (st != TX_IDLE);
        unique case (st)
            TX_START: line_nx = 1'b0;
            TX_DATA:  line_nx = sh[0];
            TX_XBIT:  line_nx = xb;
            default:  line_nx = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd <= 1'b1;
        else        txd <= line_nx;
    end

    // R1
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !txd);

    // R3
    xbit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_XBIT) |-> (cl.mp_mode || cl.par_en));

    // R5
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == TX_STOP2) |-> txd);

endmodule

// File: rtl/nbu_rx.sv
module nbu_rx
    import nbu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  frame_cfg_t        cfg,
    input  logic              rxd,
    input  logic              read,
    output logic [DATA_W-1:0] data_o,
    output logic              mp_o,
    output logic              valid_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              brk_o,
    output logic              ovr_o
);
    localparam int OVS_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         st, nx;
    logic [1:0]        sy;
    logic              rxs;
    logic [OVS_W-1:0]  ocnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              xb;
    frame_cfg_t        cl;
    logic              bit_end, mid, has_x, done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy <= 2'b11;
        else        sy <= {sy[0], rxd};
    end
    assign rxs = sy[1];

    assign bit_end = tick && (ocnt == OVS_W'(OVS - 1));
    assign mid     = tick && (ocnt == OVS_W'(OVS / 2 - 1));
    assign has_x   = cl.mp_mode || cl.par_en;
    assign done    = rx_en && bit_end &&
                     ((st == RX_STOP1 && (!rxs || !cl.two_stop)) || st == RX_STOP2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        if (!rx_en) begin
            nx = RX_IDLE;
        end else begin
            unique case (st)
                RX_IDLE:  if (!rxs) nx = RX_START;
                RX_START: if (mid) nx = rxs ? RX_IDLE : RX_DATA;
                RX_DATA:  if (bit_end && idx == IDX_W'(DATA_W - 1))
                              nx = has_x ? RX_XBIT : RX_STOP1;
                RX_XBIT:  if (bit_end) nx = RX_STOP1;
                RX_STOP1: if (bit_end)
                              nx = !rxs ? RX_REARM : (cl.two_stop ? RX_STOP2 : RX_IDLE);
                RX_STOP2: if (bit_end) nx = rxs ? RX_IDLE : RX_REARM;
                RX_REARM: if (rxs) nx = RX_IDLE;
                default:  nx = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt <= '0;
            idx  <= '0;
            sh   <= '0;
            xb   <= 1'b0;
            cl   <= '0;
        end else if (st == RX_IDLE || st == RX_REARM) begin
            ocnt <= '0;
            idx  <= '0;
            if (st == RX_IDLE && !rxs) begin
                cl <= cfg;
                xb <= 1'b0;
            end
        end else if (tick) begin
            if (st == RX_START && mid)
                ocnt <= '0;
            else
                ocnt <= bit_end ? '0 : ocnt + 1'b1;
            if (bit_end && st == RX_DATA) begin
                sh  <= {rxs, sh[DATA_W-1:1]};
                idx <= idx + 1'b1;
            end
            if (bit_end && st == RX_XBIT)
                xb <= rxs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            mp_o    <= 1'b0;
            valid_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            brk_o   <= 1'b0;
            ovr_o   <= 1'b0;
        end else if (done) begin
            data_o  <= sh;
            mp_o    <= cl.mp_mode && xb;
            valid_o <= 1'b1;
            perr_o  <= cl.par_en && !cl.mp_mode && (xb != ((^sh) ^ cl.par_odd));
            ferr_o  <= !rxs;
            brk_o   <= (st == RX_STOP1) && !rxs && (sh == '0) && !xb;
            ovr_o   <= valid_o && !read;
        end else if (read) begin
            valid_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            brk_o   <= 1'b0;
            ovr_o   <= 1'b0;
        end
    end

    // R12
    ovr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> valid_o);

    // R10
    brk_is_frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> ferr_o);

    // R4
    no_parity_in_mp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_o) |-> !cl.mp_mode);

    // R6
    rx_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (st == RX_IDLE));

    // R9
    rearm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_REARM) |=> (st != RX_START));

endmodule

// File: rtl/ninebit_uart.sv
module ninebit_uart
    import nbu_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int OVS     = 16,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rx_en,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_mp_mode,
    input  logic              cfg_two_stop,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mp_bit,
    input  logic              tx_start,
    output logic              tx_busy,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_read,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_mp_bit,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_brk,
    output logic              rx_ovr,
    output logic              rx_err
);
    frame_cfg_t cfg;
    logic       tick;

    assign cfg = '{par_en: cfg_par_en, par_odd: cfg_par_odd,
                   mp_mode: cfg_mp_mode, two_stop: cfg_two_stop};

    nbu_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    nbu_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cfg    (cfg),
        .data   (tx_data),
        .mp_bit (tx_mp_bit),
        .start  (tx_start),
        .busy   (tx_busy),
        .txd    (txd)
    );

    nbu_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_en   (cfg_rx_en),
        .cfg     (cfg),
        .rxd     (rxd),
        .read    (rx_read),
        .data_o  (rx_data),
        .mp_o    (rx_mp_bit),
        .valid_o (rx_valid),
        .perr_o  (rx_par_err),
        .ferr_o  (rx_frm_err),
        .brk_o   (rx_brk),
        .ovr_o   (rx_ovr)
    );

    assign rx_err = rx_par_err | rx_frm_err | rx_brk | rx_ovr;

endmodule

// File: tb/ninebit_uart_tb.sv
module ninebit_uart_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int BITCLK     = 16 * DIV;

    typedef struct {
        logic [11:0] bits;
        int          len;
        string       req;
    } tx_item_t;

    typedef struct {
        logic [13:0] vec;
        string       req;
    } rx_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rx_en = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_mp_mode = 1'b0, cfg_two_stop = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_mp_bit = 1'b0, tx_start = 1'b0;
    logic       tx_busy, txd;
    logic       rxd_b = 1'b1, rx_read = 1'b0;
    logic [7:0] rx_data;
    logic       rx_mp_bit, rx_valid, rx_par_err, rx_frm_err, rx_brk, rx_ovr, rx_err;

    int n_tests = 0, n_fail = 0, rx_seen = 0;
    bit finished = 1'b0, auto_read = 1'b1;
    tx_item_t txq[$];
    rx_item_t rxq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ninebit_uart #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rx_en(cfg_rx_en), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_mp_mode(cfg_mp_mode), .cfg_two_stop(cfg_two_stop),
        .tx_data(tx_data), .tx_mp_bit(tx_mp_bit), .tx_start(tx_start),
        .tx_busy(tx_busy), .txd(txd), .rxd(rxd_b), .rx_read(rx_read),
        .rx_data(rx_data), .rx_mp_bit(rx_mp_bit), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .rx_ovr(rx_ovr), .rx_err(rx_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tx_send(input logic [7:0] d, input logic mp, input bit poke, input string req);
        logic [11:0] v;
        int n;
        v = '1;
        n = 0;
        v[n] = 1'b0; n++;
        for (int i = 0; i < 8; i++) begin v[n] = d[i]; n++; end
        if (cfg_mp_mode || cfg_par_en) begin
            v[n] = cfg_mp_mode ? mp : ((^d) ^ cfg_par_odd);
            n++;
        end
        v[n] = 1'b1; n++;
        if (cfg_two_stop) begin v[n] = 1'b1; n++; end
        txq.push_back('{bits: v, len: n, req: req});
        @(negedge clk);
        tx_data = d; tx_mp_bit = mp; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        if (poke) begin
            repeat (4 * BITCLK) @(negedge clk);
            tx_data = ~d; tx_mp_bit = ~mp; tx_start = 1'b1;
            @(negedge clk);
            tx_start = 1'b0;
        end
        while (tx_busy) @(negedge clk);
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic xbit, input logic stop_ok,
                            input int hold, input bit expect_it, input string req);
        logic [11:0] v;
        int n;
        logic hx, pe, mpe, fe, bk;
        hx = cfg_mp_mode || cfg_par_en;
        v = '1;
        n = 0;
        v[n] = 1'b0; n++;
        for (int i = 0; i < 8; i++) begin v[n] = d[i]; n++; end
        if (hx) begin v[n] = xbit; n++; end
        v[n] = stop_ok; n++;
        if (cfg_two_stop && stop_ok) begin v[n] = 1'b1; n++; end
        pe  = cfg_par_en && !cfg_mp_mode && (xbit != ((^d) ^ cfg_par_odd));
        mpe = cfg_mp_mode && xbit;
        fe  = !stop_ok;
        bk  = fe && (d == 8'h00) && (!hx || !xbit);
        if (expect_it)
            rxq.push_back('{vec: {d, mpe, pe, fe, bk, 1'b0, pe | fe | bk}, req: req});
        for (int i = 0; i < n; i++) begin
            rxd_b = v[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (hold > 0) begin
            rxd_b = 1'b0;
            repeat (hold * BITCLK) @(negedge clk);
        end
        rxd_b = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    // transmit monitor: decodes the line at mid-bit and compares with the queue
    initial begin : tx_mon
        tx_item_t    e;
        logic [11:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && !txd) begin
                if (txq.size() == 0) begin
                    chk(1'b0, "R1 unexpected tx frame", 32'(txd), 32'h1);
                    while (tx_busy || !txd) @(negedge clk);
                end else begin
                    e = txq.pop_front();
                    got = '1;
                    repeat (8 * DIV) @(negedge clk);
                    got[0] = txd;
                    for (int i = 1; i < e.len; i++) begin
                        repeat (BITCLK) @(negedge clk);
                        got[i] = txd;
                    end
                    chk(got == e.bits, e.req, 32'(got), 32'(e.bits));
                end
            end
        end
    end

    // receive monitor: pops the expected frame and reads the data out
    initial begin : rx_mon
        rx_item_t e;
        logic [13:0] act;
        forever begin
            @(negedge clk);
            if (rst_n && rx_valid && auto_read) begin
                act = {rx_data, rx_mp_bit, rx_par_err, rx_frm_err, rx_brk, rx_ovr, rx_err};
                rx_seen++;
                if (rxq.size() == 0) begin
                    chk(1'b0, "R6 R7 unexpected rx frame", 32'(act), 32'h0);
                end else begin
                    e = rxq.pop_front();
                    chk(act == e.vec, e.req, 32'(act), 32'(e.vec));
                end
                rx_read = 1'b1;
                @(negedge clk);
                rx_read = 1'b0;
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seen0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 reset txd", 32'(txd), 32'h1);
        chk(tx_busy == 1'b0, "R1 reset busy", 32'(tx_busy), 32'h0);
        chk(rx_valid == 1'b0, "R11 reset valid", 32'(rx_valid), 32'h0);
        rst_n = 1'b1;
        cfg_rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // transmit side
        tx_send(8'hA5, 1'b0, 1'b0, "R2 tx 8N1 A5");
        tx_send(8'h01, 1'b0, 1'b1, "R2 tx busy ignore");
        cfg_par_en = 1'b1;
        tx_send(8'h07, 1'b0, 1'b0, "R3 tx even parity");
        cfg_par_odd = 1'b1;
        tx_send(8'h07, 1'b0, 1'b0, "R3 tx odd parity");
        cfg_mp_mode = 1'b1;
        tx_send(8'h3C, 1'b1, 1'b0, "R4 tx mp=1");
        cfg_two_stop = 1'b1;
        tx_send(8'h3C, 1'b0, 1'b0, "R5 tx mp=0 two stop");
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_mp_mode = 1'b0;
        tx_send(8'hF0, 1'b0, 1'b0, "R5 tx 8N2");
        cfg_two_stop = 1'b0;
        chk(txq.size() == 0, "R1 tx queue drained", 32'(txq.size()), 32'h0);

        // receive side
        rx_frame(8'h5A, 1'b0, 1'b1, 0, 1'b1, "R2 rx 8N1");
        chk(rx_valid == 1'b0, "R11 valid cleared by read", 32'(rx_valid), 32'h0);
        cfg_par_en = 1'b1;
        rx_frame(8'h07, 1'b1, 1'b1, 0, 1'b1, "R8 rx even good");
        rx_frame(8'h07, 1'b0, 1'b1, 0, 1'b1, "R8 rx even bad");
        cfg_par_odd = 1'b1;
        rx_frame(8'h07, 1'b1, 1'b1, 0, 1'b1, "R8 rx odd bad");
        cfg_mp_mode = 1'b1;
        rx_frame(8'hC3, 1'b1, 1'b1, 0, 1'b1, "R4 rx mp=1");
        rx_frame(8'hC3, 1'b0, 1'b1, 0, 1'b1, "R4 rx mp=0");
        cfg_two_stop = 1'b1;
        rx_frame(8'h96, 1'b1, 1'b1, 0, 1'b1, "R5 rx two stop");
        cfg_two_stop = 1'b0; cfg_mp_mode = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        rx_frame(8'h81, 1'b0, 1'b0, 0, 1'b1, "R9 rx framing");
        rx_frame(8'h00, 1'b0, 1'b0, 3, 1'b1, "R10 rx break");
        rx_frame(8'h6E, 1'b0, 1'b1, 0, 1'b1, "R9 rx after rearm");

        // R7 short glitch
        seen0 = rx_seen;
        rxd_b = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        rxd_b = 1'b1;
        repeat (24 * BITCLK) @(negedge clk);
        chk(rx_seen == seen0, "R7 glitch rejected", 32'(rx_seen), 32'(seen0));

        // R6 receiver disabled
        cfg_rx_en = 1'b0;
        seen0 = rx_seen;
        rx_frame(8'h33, 1'b0, 1'b1, 0, 1'b0, "R6");
        chk(rx_seen == seen0 && rx_valid == 1'b0, "R6 no frame while disabled",
            32'(rx_seen), 32'(seen0));
        cfg_rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R12 overrun, R13 error summary, R11 read clears
        auto_read = 1'b0;
        rx_frame(8'h11, 1'b0, 1'b1, 0, 1'b0, "R12");
        chk(rx_valid && !rx_ovr && !rx_err, "R13 no error before overrun",
            32'({rx_valid, rx_ovr, rx_err}), 32'h4);
        rx_frame(8'h22, 1'b0, 1'b1, 0, 1'b0, "R12");
        chk(rx_valid && rx_ovr, "R12 overrun flag", 32'({rx_valid, rx_ovr}), 32'h3);
        chk(rx_data == 8'h22, "R12 newest data kept", 32'(rx_data), 32'h22);
        chk(rx_err == 1'b1, "R13 error on overrun", 32'(rx_err), 32'h1);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
        @(negedge clk);
        chk(!rx_valid && !rx_ovr && !rx_err, "R11 read clears flags",
            32'({rx_valid, rx_ovr, rx_err}), 32'h0);
        auto_read = 1'b1;

        repeat (BITCLK) @(negedge clk);
        chk(rxq.size() == 0, "R11 rx queue drained", 32'(rxq.size()), 32'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule